// File: doc/BRIEF.md
# Microsecond One-Shot / Periodic Event Timer

This block is a 29-bit down-counting event timer. It advances only on cycles where an external one-microsecond tick enable is high. Software programs it through two 32-bit words in a small register window. The control word at offset 0x0 holds a run enable, a repeat-mode select and the count value V. The status word at offset 0x4 reports the live count and the interrupt flag, and a write of 1 to bit 30 of that word clears the flag. An event falls V+1 ticks after the timer is started, so a value of 0 expires on the very first tick.

An event raises an active-high level interrupt, which stays high until software clears it. In single-shot mode the timer drops back to idle after the event. In repeat mode it reloads V and keeps counting. The sequencing is a three-state machine:

- **ST_IDLE**: stopped.
- **ST_ONESHOT**: running once.
- **ST_PERIODIC**: running and repeating.

It has these transitions:

- **GO_ONE**: a control write with the enable set and repeat clear moves the machine from any state to ST_ONESHOT.
- **GO_PER**: a control write with the enable and repeat both set moves the machine from any state to ST_PERIODIC.
- **HALT**: a control write with the enable clear moves a running machine to ST_IDLE.
- **DONE**: an expiry in ST_ONESHOT moves the machine to ST_IDLE.
- **WRAP**: an expiry in ST_PERIODIC keeps the machine in ST_PERIODIC and reloads V.

Top module: `usec_event_timer`

## Requirements
- R1: After reset, irq is 0, and reads of offset 0x0 and offset 0x4 both return 0.
- R2: A write to offset 0x0 with bit 31 set loads the counter with bits [28:0] and starts the timer. The count reads back at once in bits [28:0] of offset 0x4.
- R3: While the timer runs, the count drops by one on each cycle with tick high and above zero. It holds on cycles with tick low.
- R4: After a start with value V, irq stays low through V ticks and rises after tick V+1.
- R5: In single-shot mode (bit 30 written 0), the timer stops after the event. Bit 31 of offset 0x0 then reads 0, and the count stays 0.
- R6: In repeat mode (bit 30 written 1), an event reloads V and the timer keeps running. Bit 31 of offset 0x0 still reads 1, and the next event falls after another V+1 ticks.
- R7: A write to offset 0x0 with bit 31 clear, such as a write of zero, stops the timer. The count then holds under further ticks, and no interrupt is raised.
- R8: irq stays high until a write to offset 0x4 with bit 30 set. A write to offset 0x4 with bit 30 clear leaves irq unchanged.
- R9: Offset 0x0 reads bit 31 as running, bit 30 as repeat mode and bits [28:0] as V. Offset 0x4 reads bit 30 as the interrupt flag and bits [28:0] as the live count. All other bits read 0.
- R10: When an expiry and a clear write fall in the same cycle, the expiry wins and irq stays high.
- R11: A control write in the same cycle as a tick takes effect, and that tick does not count.
- R12: The largest value, 0x1FFFFFFF, loads intact. Bit 29 of the control word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-microsecond count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset into the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Active-high level interrupt |

## Verification
The assertions assume that tick and reg_wr are synchronous single-cycle qualifiers sampled at the clock edge. They also assume that a write to any offset other than 0x0 or 0x4 has no effect. The stimulus drives every input on the falling edge and holds it for exactly one rising edge, so every write and tick is seen once. The bench deliberately makes writes coincide with ticks and clears coincide with expiries, so the priority rules in the assertions are exercised rather than avoided.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 29;
    localparam int ADDR_W   = 3;
    localparam int RUN_BIT  = 31;
    localparam int MODE_BIT = 30;
    localparam int CLR_BIT  = 30;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 3'h0;
    localparam logic [ADDR_W-1:0] STAT_OFS = 3'h4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/evt_timer_regif.sv
module evt_timer_regif
    import evt_timer_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  tmr_state_e    state,
    input  logic [CW-1:0] value,
    input  logic [CW-1:0] count,
    input  logic          irq_flag,
    output logic          ctrl_wr,
    output logic          run_bit,
    output logic          mode_bit,
    output logic [CW-1:0] wr_value,
    output logic          clr_wr,
    output logic [DW-1:0] reg_rdata
);
    assign ctrl_wr  = reg_wr && (reg_addr == CTRL_OFS);
    assign clr_wr   = reg_wr && (reg_addr == STAT_OFS) && reg_wdata[CLR_BIT];
    assign run_bit  = reg_wdata[RUN_BIT];
    assign mode_bit = reg_wdata[MODE_BIT];
    assign wr_value = reg_wdata[CW-1:0];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata[CW-1:0]   = value;
            reg_rdata[RUN_BIT]  = (state != ST_IDLE);
            reg_rdata[MODE_BIT] = (state == ST_PERIODIC);
        end else if (reg_addr == STAT_OFS) begin
            reg_rdata[CW-1:0]   = count;
            reg_rdata[CLR_BIT]  = irq_flag;
        end
    end
endmodule

// File: rtl/evt_timer_fsm.sv
module evt_timer_fsm
    import evt_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ctrl_wr,
    input  logic       run_bit,
    input  logic       mode_bit,
    input  logic       cnt_zero,
    output tmr_state_e state,
    output logic       running,
    output logic       expire,
    output logic       reload,
    output logic       dec
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (!run_bit)      state_d = ST_IDLE;
            else if (mode_bit) state_d = ST_PERIODIC;
            else               state_d = ST_ONESHOT;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ONESHOT:  if (expire) state_d = ST_IDLE;
                ST_PERIODIC: state_d = ST_PERIODIC;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = 1'b0;
        expire  = 1'b0;
        reload  = 1'b0;
        dec     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ONESHOT: begin
                running = 1'b1;
                expire  = tick && !ctrl_wr && cnt_zero;
                dec     = tick && !ctrl_wr && !cnt_zero;
            end
            ST_PERIODIC: begin
                running = 1'b1;
                expire  = tick && !ctrl_wr && cnt_zero;
                reload  = expire;
                dec     = tick && !ctrl_wr && !cnt_zero;
            end
            default: ;
        endcase
    end

    assign state = state_q;

    assert_oneshot_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state_q == ST_ONESHOT) |=> state_q == ST_IDLE);
    assert_periodic_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state_q == ST_PERIODIC) |=> state_q == ST_PERIODIC);
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && run_bit) |=> state_q != ST_IDLE);
endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
    parameter int CW = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          run_bit,
    input  logic [CW-1:0] wr_value,
    input  logic          dec,
    input  logic          reload,
    output logic [CW-1:0] value,
    output logic [CW-1:0] count,
    output logic          cnt_zero
);
    logic [CW-1:0] value_q, count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            count_q <= '0;
        end else begin
            if (ctrl_wr) value_q <= wr_value;
            if (ctrl_wr && run_bit) count_q <= wr_value;
            else if (reload)        count_q <= value_q;
            else if (dec)           count_q <= count_q - 1'b1;
        end
    end

    assign value    = value_q;
    assign count    = count_q;
    assign cnt_zero = (count_q == '0);

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> count_q != '0);
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !dec && !reload) |=> $stable(count_q));
    assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !ctrl_wr) |=> count_q == value_q);
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_wr,
    output logic irq_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_flag <= 1'b0;
        else if (expire) irq_flag <= 1'b1;
        else if (clr_wr) irq_flag <= 1'b0;
    end

    assert_expire_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_flag);
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_wr) |=> irq_flag);
    assert_expire_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && clr_wr) |=> irq_flag);
endmodule

// File: rtl/usec_event_timer.sv
module usec_event_timer
    import evt_timer_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    tmr_state_e    state;
    logic          ctrl_wr, run_bit, mode_bit, clr_wr;
    logic [CW-1:0] wr_value, value, count;
    logic          cnt_zero, running, expire, reload, dec, irq_flag;

    evt_timer_regif #(.DW(DW), .CW(CW), .AW(AW)) u_regif (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .state(state), .value(value), .count(count), .irq_flag(irq_flag),
        .ctrl_wr(ctrl_wr), .run_bit(run_bit), .mode_bit(mode_bit),
        .wr_value(wr_value), .clr_wr(clr_wr), .reg_rdata(reg_rdata)
    );

    evt_timer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
        .run_bit(run_bit), .mode_bit(mode_bit), .cnt_zero(cnt_zero),
        .state(state), .running(running), .expire(expire),
        .reload(reload), .dec(dec)
    );

    evt_timer_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .run_bit(run_bit),
        .wr_value(wr_value), .dec(dec), .reload(reload),
        .value(value), .count(count), .cnt_zero(cnt_zero)
    );

    evt_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_wr(clr_wr),
        .irq_flag(irq_flag)
    );

    assign irq = irq_flag;

    assert_irq_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_wr));
    assert_idle_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_wr) |=> $stable(count));
endmodule

// File: tb/test_usec_event_timer.sv
module test_usec_event_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    usec_event_timer i_usec_event_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    // entries: bit 30 = repeat mode, bits [28:0] = value
    localparam logic [31:0] VEC [5] = '{
        32'h0000_0000, 32'h0000_0001, 32'h4000_0007,
        32'h0000_0003, 32'h4000_000C
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: inputs set at negedge, captured at posedge, back at next negedge
    task automatic step(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
        tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'h0, '0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 200000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'h0, d); chk("R1 ctrl", d, 32'h0);
        rd(3'h4, d); chk("R1 stat", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // table walk: R2 R4 R5 R6 R8
        for (int k = 0; k < 5; k++) begin
            logic [28:0] v;
            logic        per;
            v   = VEC[k][28:0];
            per = VEC[k][30];
            step(1'b0, 1'b1, 3'h0, VEC[k] | 32'h8000_0000);
            rd(3'h4, d); chk("R2 load", d, {3'b000, v});
            if (v != 0) begin
                ticks(int'(v));
                rd(3'h4, d); chk("R4 before expiry", d, 32'h0);
            end
            ticks(1);
            chk("R4 irq after V+1", {31'h0, irq}, 32'h1);
            if (per) begin
                rd(3'h0, d); chk("R6 still running", d, {2'b11, 1'b0, v});
                rd(3'h4, d); chk("R6 reload", d, {3'b010, v});
                ticks(int'(v) + 1);
                rd(3'h4, d); chk("R6 second period", d, {3'b010, v});
            end else begin
                rd(3'h0, d); chk("R5 stopped", d, {3'b000, v});
                ticks(2);
                rd(3'h4, d); chk("R5 count stays 0", d, 32'h4000_0000);
            end
            step(1'b0, 1'b1, 3'h4, 32'h4000_0000);
            chk("R8 clear", {31'h0, irq}, 32'h0);
            step(1'b0, 1'b1, 3'h0, 32'h0);
        end

        // R9 readback layout
        step(1'b0, 1'b1, 3'h0, 32'hC000_0005);
        rd(3'h0, d); chk("R9 ctrl layout", d, 32'hC000_0005);
        rd(3'h4, d); chk("R9 stat layout", d, 32'h0000_0005);

        // R3 tick low holds, tick high decrements
        step(1'b0, 1'b0, 3'h0, '0); step(1'b0, 1'b0, 3'h0, '0);
        rd(3'h4, d); chk("R3 hold", d, 32'h5);
        ticks(2);
        rd(3'h4, d); chk("R3 decrement", d, 32'h3);

        // R7 stop with zero write
        step(1'b0, 1'b1, 3'h0, 32'h0);
        ticks(6);
        rd(3'h4, d); chk("R7 count holds", d, 32'h3);
        chk("R7 no irq", {31'h0, irq}, 32'h0);
        rd(3'h0, d); chk("R7 ctrl reads idle", d, 32'h0);

        // R8 clear write with bit 30 clear does nothing
        step(1'b0, 1'b1, 3'h0, 32'h8000_0000);
        ticks(1);
        chk("R8 irq set", {31'h0, irq}, 32'h1);
        step(1'b0, 1'b1, 3'h4, 32'hBFFF_FFFF);
        chk("R8 bit30 clear ignored", {31'h0, irq}, 32'h1);
        step(1'b0, 1'b1, 3'h4, 32'h4000_0000);
        chk("R8 cleared", {31'h0, irq}, 32'h0);

        // R10 expiry and clear in one cycle
        step(1'b0, 1'b1, 3'h0, 32'hC000_0000);
        ticks(1);
        chk("R10 setup", {31'h0, irq}, 32'h1);
        step(1'b1, 1'b1, 3'h4, 32'h4000_0000);
        chk("R10 expiry wins", {31'h0, irq}, 32'h1);
        step(1'b0, 1'b1, 3'h0, 32'h0);
        step(1'b0, 1'b1, 3'h4, 32'h4000_0000);
        chk("R10 clear alone", {31'h0, irq}, 32'h0);

        // R11 write coincides with tick
        step(1'b0, 1'b1, 3'h0, 32'h8000_0005);
        ticks(2);
        step(1'b1, 1'b1, 3'h0, 32'h8000_0009);
        rd(3'h4, d); chk("R11 write wins over tick", d, 32'h9);
        ticks(1);
        rd(3'h4, d); chk("R11 next tick counts", d, 32'h8);

        // R12 largest value, bit 29 ignored
        step(1'b0, 1'b1, 3'h0, 32'hFFFF_FFFF);
        rd(3'h0, d); chk("R12 ctrl", d, 32'hDFFF_FFFF);
        rd(3'h4, d); chk("R12 count", d, 32'h1FFF_FFFF);
        ticks(1);
        rd(3'h4, d); chk("R12 decrement", d, 32'h1FFF_FFFE);
        step(1'b0, 1'b1, 3'h0, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule